// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the two low-power control bits of a small microcontroller and turns them into clock enables, an oscillator enable and forced levels for the external bus strobes. Software enters a low-power state by writing a control register on the special-function-register write port. The block then derives every gating and override signal from its single internal mode state.

There are two low-power states. In the light sleep state the processor clock stops, but the interrupt, timer and serial clocks keep running. The address-latch and program-store strobes are held high. Any enabled interrupt or any reset wakes the chip.

In the deep sleep state every clock and the oscillator stop, and both strobes are driven low. The external memory-select line is held at its inactive (high) level unless a configuration input has turned that line into general-purpose I/O. Only a reset ends deep sleep.

All pins are plain control and status levels. There is no data stream, so the block has no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `ext_rst` or `int_rst` is high at a clock edge, the block returns to run mode. In run mode `cpu_clk_en`, every bit of `periph_clk_en` and `osc_en` are 1, and `strobe_force` and `memsel_force` are 0.
- R2: A write with `sfr_addr` = 0x87 and `sfr_wdata` bit 0 = 1 (bit 1 = 0) enters light sleep at that edge. In light sleep `cpu_clk_en` = 0, while all `periph_clk_en` bits and `osc_en` stay 1.
- R3: In light sleep `strobe_force` = 1 and `strobe_level` = 1, and `memsel_force` = 0.
- R4: In light sleep, `irq` high at a clock edge returns the block to run mode at that edge.
- R5: A write with `sfr_addr` = 0x87 and `sfr_wdata` bit 1 = 1 enters deep sleep. In deep sleep `cpu_clk_en`, every `periph_clk_en` bit and `osc_en` are 0.
- R6: In deep sleep `strobe_force` = 1 and `strobe_level` = 0.
- R7: In deep sleep `memsel_force` = 1 when `cfg_memsel_gpio` = 0, and 0 when it is 1. Outside deep sleep `memsel_force` is 0.
- R8: In deep sleep, `irq` has no effect.
- R9: A write with both bit 0 and bit 1 set enters deep sleep, not light sleep.
- R10: These writes change nothing: a write to any address other than 0x87, a write of 0x87 with bits 1:0 both 0, and any write made while in light or deep sleep.
- R11: `int_rst` alone ends deep sleep and light sleep exactly as `ext_rst` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock for this controller |
| ext_rst | input | 1 | Synchronous reset from the reset pin, active high |
| int_rst | input | 1 | Synchronous reset from an internal source, active high |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | ADDR_W (8) | Register write address |
| sfr_wdata | input | DATA_W (8) | Register write data; bit 0 requests light sleep, bit 1 requests deep sleep |
| irq | input | 1 | Enabled interrupt request |
| cfg_memsel_gpio | input | 1 | 1 = memory-select pin is used as general-purpose I/O |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | N_PERIPH (3) | Enables for the interrupt, timer and serial clocks |
| osc_en | output | 1 | Oscillator enable |
| strobe_force | output | 1 | Overrides the address-latch and program-store strobes |
| strobe_level | output | 1 | Level driven on both strobes while overridden |
| memsel_force | output | 1 | Drives the memory-select line to its inactive high level |

## Verification
The hardest state to reach from the ports is deep sleep while an interrupt arrives, a register write is attempted and the configuration input toggles, all before a reset. The bench has to show that none of these events moves the state.

Directed sequences walk into deep sleep and then apply each of these events in turn. Longer constrained-random runs hold reset rare and aim writes at address 0x87, so that sleep states last many cycles under mixed traffic.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } pwr_mode_t;

  localparam int unsigned LIGHT_BIT = 0;
  localparam int unsigned DEEP_BIT  = 1;
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_hit,
  input  logic      req_light,
  input  logic      req_deep,
  input  logic      wake,
  output pwr_mode_t mode
);
  pwr_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        // deep request wins over light when both are written
        if (wr_hit && req_deep)       mode_d = MODE_DEEP;
        else if (wr_hit && req_light) mode_d = MODE_LIGHT;
      end
      MODE_LIGHT: if (wake) mode_d = MODE_RUN;
      MODE_DEEP:  mode_d = MODE_DEEP;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_PERIPH = 3
) (
  input  pwr_mode_t           mode,
  input  logic                cfg_memsel_gpio,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                osc_en,
  output logic                strobe_force,
  output logic                strobe_level,
  output logic                memsel_force
);
  logic in_run, in_light, in_deep;

  assign in_run   = (mode == MODE_RUN);
  assign in_light = (mode == MODE_LIGHT);
  assign in_deep  = (mode == MODE_DEEP);

  assign cpu_clk_en = in_run;
  assign osc_en     = !in_deep;

  genvar g;
  generate
    for (g = 0; g < N_PERIPH; g++) begin : g_periph
      assign periph_clk_en[g] = !in_deep;
    end
  endgenerate

  assign strobe_force = in_light || in_deep;
  assign strobe_level = in_light;
  assign memsel_force = in_deep && !cfg_memsel_gpio;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       N_PERIPH  = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h87
) (
  input  logic                clk,
  input  logic                ext_rst,
  input  logic                int_rst,
  input  logic                sfr_we,
  input  logic [ADDR_W-1:0]   sfr_addr,
  input  logic [DATA_W-1:0]   sfr_wdata,
  input  logic                irq,
  input  logic                cfg_memsel_gpio,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                osc_en,
  output logic                strobe_force,
  output logic                strobe_level,
  output logic                memsel_force
);
  logic      rst_any;
  logic      wr_hit;
  pwr_mode_t mode;

  assign rst_any = ext_rst || int_rst;
  assign wr_hit  = sfr_we && (sfr_addr == CTRL_ADDR);

  pwr_mode_reg u_reg (
    .clk       (clk),
    .rst       (rst_any),
    .wr_hit    (wr_hit),
    .req_light (sfr_wdata[LIGHT_BIT]),
    .req_deep  (sfr_wdata[DEEP_BIT]),
    .wake      (irq),
    .mode      (mode)
  );

  pwr_out_map #(.N_PERIPH(N_PERIPH)) u_map (
    .mode            (mode),
    .cfg_memsel_gpio (cfg_memsel_gpio),
    .cpu_clk_en      (cpu_clk_en),
    .periph_clk_en   (periph_clk_en),
    .osc_en          (osc_en),
    .strobe_force    (strobe_force),
    .strobe_level    (strobe_level),
    .memsel_force    (memsel_force)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int unsigned N_PERIPH = 3
) (
  input logic                clk,
  input logic                ext_rst,
  input logic                int_rst,
  input logic                irq,
  input logic                sfr_we,
  input logic                cfg_memsel_gpio,
  input logic                cpu_clk_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic                osc_en,
  input logic                strobe_force,
  input logic                strobe_level,
  input logic                memsel_force
);
  p_light_periph_on_r2: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    (!cpu_clk_en && osc_en) |-> (&periph_clk_en));

  p_strobe_levels_r3: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    strobe_force |-> (strobe_level == osc_en));

  p_light_wake_r4: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    (strobe_force && osc_en && irq) |=> cpu_clk_en);

  p_deep_all_off_r5: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    !osc_en |-> (periph_clk_en == '0 && !cpu_clk_en && strobe_force));

  p_memsel_rule_r7: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    memsel_force |-> (!osc_en && !cfg_memsel_gpio));

  p_deep_sticky_r8: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    !osc_en |=> !osc_en);

  p_light_no_write_r10: assert property (@(posedge clk) disable iff (ext_rst || int_rst)
    (strobe_force && osc_en && !irq && sfr_we) |=> (strobe_force && osc_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk             (clk),
  .ext_rst         (ext_rst),
  .int_rst         (int_rst),
  .irq             (irq),
  .sfr_we          (sfr_we),
  .cfg_memsel_gpio (cfg_memsel_gpio),
  .cpu_clk_en      (cpu_clk_en),
  .periph_clk_en   (periph_clk_en),
  .osc_en          (osc_en),
  .strobe_force    (strobe_force),
  .strobe_level    (strobe_level),
  .memsel_force    (memsel_force)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int NP = 3;
  localparam int OW = NP + 5;

  logic clk = 1'b0;
  logic ext_rst = 1'b1, int_rst = 1'b0, sfr_we = 1'b0, irq = 1'b0, gpio = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic cpu_clk_en, osc_en, strobe_force, strobe_level, memsel_force;
  logic [NP-1:0] periph_clk_en;

  int total = 0, bad = 0;
  logic [1:0] st = 2'd0;   // 0 run, 1 light sleep, 2 deep sleep
  bit done = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .ext_rst(ext_rst), .int_rst(int_rst), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .irq(irq),
    .cfg_memsel_gpio(gpio), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .strobe_force(strobe_force), .strobe_level(strobe_level),
    .memsel_force(memsel_force)
  );

  function automatic logic [1:0] model_next(logic [1:0] s, logic rst, logic we,
      logic [7:0] a, logic [7:0] d, logic i);
    if (rst) return 2'd0;
    case (s)
      2'd0: if (we && a == 8'h87 && d[1]) return 2'd2;
            else if (we && a == 8'h87 && d[0]) return 2'd1;
      2'd1: if (i) return 2'd0;
      default: ;
    endcase
    return s;
  endfunction

  function automatic logic [OW-1:0] model_out(logic [1:0] s, logic g);
    logic dp = (s == 2'd2);
    return {s == 2'd0, dp ? {NP{1'b0}} : {NP{1'b1}}, !dp, s != 2'd0, s == 2'd1, dp && !g};
  endfunction

  task automatic check(string tag);
    logic [OW-1:0] act, exp;
    act = {cpu_clk_en, periph_clk_en, osc_en, strobe_force, strobe_level, memsel_force};
    exp = model_out(st, gpio);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(logic er, logic ir, logic we, logic [7:0] a, logic [7:0] d,
      logic i, logic g, string tag);
    ext_rst = er; int_rst = ir; sfr_we = we; sfr_addr = a; sfr_wdata = d; irq = i; gpio = g;
    @(posedge clk);
    st = model_next(st, er || ir, we, a, d, i);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(1, 0, 0, 8'h00, 8'h00, 0, 0, "R1 reset state");
    step(0, 0, 1, 8'h86, 8'h03, 0, 0, "R10 other address");
    step(0, 0, 1, 8'h87, 8'hFC, 0, 0, "R10 zero bits");
    step(0, 0, 0, 8'h00, 8'h00, 1, 0, "R4 irq in run no effect");
    step(0, 0, 1, 8'h87, 8'h01, 0, 0, "R2 enter light");
    step(0, 0, 0, 8'h00, 8'h00, 0, 1, "R3 light strobes, gpio cfg");
    step(0, 0, 1, 8'h87, 8'h02, 0, 0, "R10 write in light ignored");
    step(0, 0, 0, 8'h00, 8'h00, 1, 0, "R4 irq wakes");
    step(0, 0, 1, 8'h87, 8'h02, 0, 0, "R5 enter deep");
    step(0, 0, 0, 8'h00, 8'h00, 0, 0, "R6 R7 deep strobes memsel forced");
    step(0, 0, 0, 8'h00, 8'h00, 0, 1, "R7 memsel as gpio");
    step(0, 0, 0, 8'h00, 8'h00, 1, 0, "R8 irq ignored in deep");
    step(0, 0, 1, 8'h87, 8'h01, 0, 0, "R10 write in deep ignored");
    step(0, 1, 0, 8'h00, 8'h00, 0, 0, "R11 internal reset leaves deep");
    step(0, 0, 1, 8'h87, 8'h03, 0, 0, "R9 both bits give deep");
    step(1, 0, 0, 8'h00, 8'h00, 0, 0, "R1 pin reset leaves deep");
    step(0, 0, 1, 8'h87, 8'h01, 0, 0, "R2 light again");
    step(0, 1, 0, 8'h00, 8'h00, 0, 0, "R11 internal reset leaves light");
    for (int n = 0; n < 4000; n++) begin
      logic er, ir, we, i, g;
      logic [7:0] a, d;
      er = ($urandom % 60) == 0;
      ir = ($urandom % 60) == 0;
      we = ($urandom % 4) == 0;
      a  = ($urandom % 2) ? 8'h87 : 8'($urandom);
      d  = 8'($urandom);
      i  = ($urandom % 5) == 0;
      g  = ($urandom % 2) == 1;
      step(er, ir, we, a, d, i, g, "R10 random mix R8");
    end
    finish_run();
  end
endmodule